// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Program Unlock

This block lets a processor read and burn rows of a one-time-programmable fuse array through a small memory-mapped register set. Software first enables processor access in the mode register. It then picks a command and a row address, fills the write-data words and sets the start bit. While the block works, software polls the status register until the done flag appears, and then clears the start bit. Clearing the start bit also drops the done flag.

Burning fuses needs an unlock. Software issues the program-enable command four times, with a fixed key word loaded before each step. Each program then ORs the write data into the addressed row, so a bit can only go from 0 to 1. The time a program takes grows with the number of 1 bits written. A parameter sets the row width to one or two 32-bit words. The fuse array is modelled with flip-flops.

Top module: `otp_ctrl`

## Requirements
- R1: After reset, every register reads back as zero: mode (0x00), command (0x04), start (0x08), status (0x0C), row address (0x28) and both read-data words (0x10, 0x5C). The fuse array is also all zero.
- R2: While bit 0 of the mode register (0x00) is 0, setting the start bit launches nothing. The status register stays 0.
- R3: The command register (0x04) keeps only the low 6 bits written to it. The command codes are: read 0x00, program-enable 0x02, program-disable 0x03, program-row 0x08. Any other code completes without effect.
- R4: The row-address register (0x28) keeps only the low 16 bits written to it. The low log2(ROWS) bits select the row.
- R5: A command launches when bit 0 of the start register (0x08) goes from 0 to 1 while the block is idle and done is clear. Status bit 1 (done) then stays set until software writes 0 to the start bit.
- R6: A read completes READ_CYCLES cycles after launch. It copies the addressed row into the read-data words.
- R7: Four program-enable commands with write-data word 0 equal to 0xF, 0x4, 0x8 and 0xD, in that order, unlock programming. After the fourth one, status bit 2 (program-OK) is 1. It is 0 after each of the first three steps.
- R8: A program-enable command with a wrong key word sends the unlock tracker back to its first step. It also clears any unlock and status bit 2. A valid sequence must then start again from 0xF.
- R9: A program-row command without an active unlock completes with done set. It leaves the array unchanged and clears status bit 2.
- R10: An unlocked program-row command ORs the write data into the addressed row and sets status bit 2. Stored bits never return to 0.
- R11: A program-row command takes PROG_BASE + PROG_PER_BIT × (number of 1 bits in the write data) cycles. Any other command except read takes CTRL_CYCLES cycles.
- R12: Program-disable (0x03) completes with done and status bit 2 set and removes the unlock. A later program-row command has no effect.
- R13: With ROW_WORDS = 2, each row is 64 bits wide. The second read word is at 0x5C and the second write word is at 0x64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |

## Verification
The bench sweeps every row of an eight-row, two-word configuration. It checks read timing and compares data against a model array that it ORs itself. A design that overwrote a row instead of OR-ing would lose the first pattern of a row programmed twice.

The unlock checks feed a wrong key in the middle of the sequence and then finish it out of order. A tracker that did not restart would wrongly report program-OK. Programs are also issued while locked and after a disable; a leaky gate would burn fuses there.

Program durations are measured cycle by cycle for many bit counts, up to all 64 ones. A wrong per-bit cost or an off-by-one in the busy counter therefore shows up as a wrong count.

// File: rtl/otp_ctrl.sv
module otp_ctrl #(
  parameter int ROWS         = 8,
  parameter int ROW_WORDS    = 2,
  parameter int READ_CYCLES  = 3,
  parameter int CTRL_CYCLES  = 2,
  parameter int PROG_BASE    = 4,
  parameter int PROG_PER_BIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int ROW_W   = 32 * ROW_WORDS;
  localparam int IDX_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int MAX_DUR = PROG_BASE + PROG_PER_BIT * ROW_W + READ_CYCLES + CTRL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08, A_STAT = 8'h0C;
  localparam logic [7:0] A_RD0 = 8'h10, A_ADDR = 8'h28, A_WD0 = 8'h2C, A_RD1 = 8'h5C, A_WD1 = 8'h64;
  localparam logic [5:0] C_READ = 6'h00, C_UNLOCK = 6'h02, C_LOCK = 6'h03, C_PROG = 6'h08;

  logic             mode_q, start_q, done_q, ok_q, busy_q, unlocked_q;
  logic [5:0]       cmd_q, op_cmd;
  logic [15:0]      addr_q;
  logic [ROW_W-1:0] wdata_q, rdata_q, op_data;
  logic [IDX_W-1:0] op_idx;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       step_q;
  logic [ROW_W-1:0] fuse_q [ROWS];

  function automatic logic [31:0] key_at(input logic [1:0] s);
    case (s)
      2'd0:    return 32'hF;
      2'd1:    return 32'h4;
      2'd2:    return 32'h8;
      default: return 32'hD;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] dur_of(input logic [5:0] c, input logic [ROW_W-1:0] d);
    int n;
    if (c == C_PROG)      n = PROG_BASE + PROG_PER_BIT * $countones(d);
    else if (c == C_READ) n = READ_CYCLES;
    else                  n = CTRL_CYCLES;
    return CNT_W'(n - 1);
  endfunction

  wire wr_start = bus_wr && (bus_addr == A_START);
  wire launch   = wr_start && bus_wdata[0] && !start_q && mode_q && !busy_q && !done_q;
  wire finish   = busy_q && (cnt_q == '0);
  wire key_hit  = (op_data[31:0] == key_at(step_q));
  wire burn     = finish && (op_cmd == C_PROG) && unlocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
      busy_q     <= 1'b0;
      unlocked_q <= 1'b0;
      cmd_q      <= '0;
      op_cmd     <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      op_data    <= '0;
      op_idx     <= '0;
      cnt_q      <= '0;
      step_q     <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_MODE:  mode_q         <= bus_wdata[0];
          A_CMD:   cmd_q          <= bus_wdata[5:0];
          A_START: start_q        <= bus_wdata[0];
          A_ADDR:  addr_q         <= bus_wdata[15:0];
          A_WD0:   wdata_q[31:0]  <= bus_wdata;
          default: ;
        endcase
        if (ROW_WORDS == 2 && bus_addr == A_WD1) wdata_q[ROW_W-1 -: 32] <= bus_wdata;
      end
      if (wr_start && !bus_wdata[0]) done_q <= 1'b0;

      if (launch) begin
        busy_q  <= 1'b1;
        cnt_q   <= dur_of(cmd_q, wdata_q);
        op_cmd  <= cmd_q;
        op_idx  <= addr_q[IDX_W-1:0];
        op_data <= wdata_q;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          case (op_cmd)
            C_READ: begin
              rdata_q <= fuse_q[op_idx];
              step_q  <= '0;
            end
            C_UNLOCK: begin
              if (!key_hit) begin
                step_q     <= '0;
                unlocked_q <= 1'b0;
                ok_q       <= 1'b0;
              end else if (step_q == 2'd3) begin
                step_q     <= '0;
                unlocked_q <= 1'b1;
                ok_q       <= 1'b1;
              end else begin
                step_q <= step_q + 2'd1;
                ok_q   <= 1'b0;
              end
            end
            C_LOCK: begin
              unlocked_q <= 1'b0;
              step_q     <= '0;
              ok_q       <= 1'b1;
            end
            C_PROG: begin
              ok_q   <= unlocked_q;
              step_q <= '0;
            end
            default: step_q <= '0;
          endcase
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) fuse_q[i] <= '0;
    end else if (burn) begin
      fuse_q[op_idx] <= fuse_q[op_idx] | op_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = {31'b0, mode_q};
      A_CMD:   bus_rdata = {26'b0, cmd_q};
      A_START: bus_rdata = {31'b0, start_q};
      A_STAT:  bus_rdata = {29'b0, ok_q, done_q, 1'b0};
      A_ADDR:  bus_rdata = {16'b0, addr_q};
      A_RD0:   bus_rdata = rdata_q[31:0];
      default: ;
    endcase
    if (ROW_WORDS == 2 && bus_addr == A_RD1) bus_rdata = rdata_q[ROW_W-1 -: 32];
  end

  AST_DONE_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !busy_q);            // R5
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) |-> start_q);     // R5
  AST_MODE_GATE:  assert property (@(posedge clk) disable iff (!rst_n) (!mode_q && !busy_q) |=> !busy_q); // R2
  AST_UNLOCK_OK:  assert property (@(posedge clk) disable iff (!rst_n) $rose(unlocked_q) |-> ok_q);    // R7

  for (genvar g = 0; g < ROWS; g++) begin : g_fuse_chk
    AST_FUSE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_q[g] & $past(fuse_q[g])) == $past(fuse_q[g]));                                          // R10
    AST_FUSE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(unlocked_q) |-> $stable(fuse_q[g]));                                                    // R9
  end
endmodule

// File: tb/test_otp_ctrl.sv
module test_otp_ctrl;
  localparam int ROWS = 8, RW = 2, RD = 3, CT = 2, PB = 4, PPB = 2;
  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08, A_STAT = 8'h0C;
  localparam logic [7:0] A_RD0 = 8'h10, A_ADDR = 8'h28, A_WD0 = 8'h2C, A_RD1 = 8'h5C, A_WD1 = 8'h64;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  wire  [31:0] bus_rdata;

  always #10 clk = ~clk;

  otp_ctrl #(.ROWS(ROWS), .ROW_WORDS(RW), .READ_CYCLES(RD), .CTRL_CYCLES(CT),
             .PROG_BASE(PB), .PROG_PER_BIT(PPB)) i_otp_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int checks = 0, errors = 0;
  logic [63:0] model [ROWS];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run(input logic [5:0] c, input logic [15:0] row, input logic [31:0] d0,
                     input logic [31:0] d1, output int cyc, output logic [31:0] st);
    wr(A_CMD, {26'b0, c});
    wr(A_ADDR, {16'b0, row});
    wr(A_WD0, d0);
    wr(A_WD1, d1);
    wr(A_START, 1);
    cyc = 0;
    bus_addr = A_STAT;
    #1;
    while (!bus_rdata[1] && cyc < 1000) begin
      cyc++;
      @(negedge clk);
      #1;
    end
    st = bus_rdata;
    wr(A_START, 0);
  endtask

  task automatic read_row(input int r, output logic [63:0] v, output int cyc);
    logic [31:0] st, lo, hi;
    run(6'h00, 16'(r), 32'h0, 32'h0, cyc, st);
    rd(A_RD0, lo);
    rd(A_RD1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] st, d;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(A_MODE, d);  chk("R1 mode", d, 0);
    rd(A_CMD, d);   chk("R1 cmd", d, 0);
    rd(A_START, d); chk("R1 start", d, 0);
    rd(A_STAT, d);  chk("R1 status", d, 0);
    rd(A_ADDR, d);  chk("R1 addr", d, 0);
    rd(A_RD0, d);   chk("R1 rd0", d, 0);
    rd(A_RD1, d);   chk("R1 rd1", d, 0);

    // R2: start without access enabled
    wr(A_START, 1);
    repeat (12) @(negedge clk);
    rd(A_STAT, d); chk("R2 status stays idle", d, 0);
    wr(A_START, 0);

    wr(A_MODE, 1);
    wr(A_CMD, 32'hFFFF_FFFF); rd(A_CMD, d); chk("R3 cmd masked", d, 32'h3F);
    wr(A_ADDR, 32'hABCD_1234); rd(A_ADDR, d); chk("R4 addr masked", d, 32'h1234);

    for (int r = 0; r < ROWS; r++) begin
      model[r] = 64'h0;
      read_row(r, v, cyc);
      chk("R6 read latency", 64'(cyc), 64'(RD));
      chk("R1 blank row", v, 64'h0);
    end

    // R5: done held while start stays 1, cleared by writing 0
    wr(A_CMD, 0);
    wr(A_START, 1);
    repeat (RD + 20) @(negedge clk);
    rd(A_STAT, d); chk("R5 done held", 64'(d[1]), 1);
    wr(A_START, 1);
    rd(A_STAT, d); chk("R5 no relaunch", 64'(d[1]), 1);
    wr(A_START, 0);
    rd(A_STAT, d); chk("R5 done cleared", 64'(d[1]), 0);

    // R9: program while locked
    run(6'h08, 3, 32'h0000_00FF, 32'h1, cyc, st);
    chk("R9 done", 64'(st[1]), 1);
    chk("R9 ok clear", 64'(st[2]), 0);
    chk("R11 locked program time", 64'(cyc), 64'(PB + PPB * 9));
    read_row(3, v, cyc); chk("R9 row unchanged", v, 64'h0);

    // R8: wrong key mid-sequence, then out-of-order tail
    run(6'h02, 0, 32'hF, 0, cyc, st);
    chk("R11 enable time", 64'(cyc), 64'(CT));
    run(6'h02, 0, 32'h4, 0, cyc, st);
    run(6'h02, 0, 32'h7, 0, cyc, st); chk("R8 bad key ok", 64'(st[2]), 0);
    run(6'h02, 0, 32'h8, 0, cyc, st);
    run(6'h02, 0, 32'hD, 0, cyc, st); chk("R8 out of order ok", 64'(st[2]), 0);
    run(6'h08, 1, 32'h5, 32'h5, cyc, st);
    read_row(1, v, cyc); chk("R8 still locked", v, 64'h0);

    // R7: correct sequence
    run(6'h02, 0, 32'hF, 0, cyc, st); chk("R7 step1 ok", 64'(st[2]), 0);
    run(6'h02, 0, 32'h4, 0, cyc, st); chk("R7 step2 ok", 64'(st[2]), 0);
    run(6'h02, 0, 32'h8, 0, cyc, st); chk("R7 step3 ok", 64'(st[2]), 0);
    run(6'h02, 0, 32'hD, 0, cyc, st); chk("R7 step4 ok", 64'(st[2]), 1);

    // R10/R11/R13: program sweep
    for (int r = 0; r < ROWS; r++) begin
      logic [31:0] p0, p1;
      p0 = 32'h0101_0101 * (r + 1);
      p1 = 32'h8000_0000 >> r;
      run(6'h08, 16'(r), p0, p1, cyc, st);
      model[r] = model[r] | {p1, p0};
      chk("R10 ok set", 64'(st[2]), 1);
      chk("R11 program time", 64'(cyc), 64'(PB + PPB * ($countones(p0) + $countones(p1))));
    end
    run(6'h08, 2, 32'h0000_F000, 32'h0F00_0000, cyc, st);
    model[2] = model[2] | {32'h0F00_0000, 32'h0000_F000};
    for (int r = 0; r < ROWS; r++) begin
      read_row(r, v, cyc);
      chk("R10 R13 row contents", v, model[r]);
    end

    // R12: disable, then a full-ones program must not burn
    run(6'h03, 0, 0, 0, cyc, st);
    chk("R12 done", 64'(st[1]), 1);
    chk("R12 ok", 64'(st[2]), 1);
    run(6'h08, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, cyc, st);
    chk("R11 full-ones time", 64'(cyc), 64'(PB + PPB * 64));
    chk("R12 ok after locked program", 64'(st[2]), 0);
    read_row(0, v, cyc); chk("R12 row 0 unchanged", v, model[0]);

    // R3: unknown code completes without effect
    run(6'h3F, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, cyc, st);
    chk("R3 unknown done", 64'(st[1]), 1);
    read_row(5, v, cyc); chk("R3 unknown no write", v, model[5]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule